// File: doc/BRIEF.md
# Collision-Checked Packet Transmit Controller

This block runs a single packet transmission on a single-ended channel. Once a start request is accepted, it raises a transmit-enable output. It then follows the preamble, body and trailing code-violation phases as the line encoder reports each one finished. The transceiver supplies an active-low collision input. Whenever detection is enabled, any low level on that input during a transmission sets a sticky flag.

The flag only affects the outcome at two checkpoints. The first is the end of the preamble. The second is the end of the packet body. A collision found at the preamble checkpoint ends the attempt at once, and the block sends a one-cycle retry pulse to the upper layer. A collision found at the packet checkpoint turns the normal done pulse into a retry pulse. That pulse is issued once the code violation has gone out. The upper layer therefore gets a resend request right away and does not have to wait for an acknowledgment timer to expire. The transmit-enable output is a driven logic level at all times and is low whenever no transmission is in progress.

Top module: `txcoll_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `tx_en_o`, `done_o` and `retry_o` are all 0, even if a transmission was in progress when reset arrived.
- R2: A `start_i` sampled while idle makes `tx_en_o` 1 from the next cycle onward.
- R3: When `cd_en_i` is 1, a low level on `coll_n_i` lasting one clock during the preamble, or in the same cycle as `pre_done_i`, causes a one-cycle `retry_o` and `tx_en_o` low in the cycle after `pre_done_i`.
- R4: When `cd_en_i` is 0, `coll_n_i` has no effect and every transmission ends with `done_o`.
- R5: A transmission with no collision ends with `done_o` high for exactly one cycle and `tx_en_o` low, both in the cycle after `cv_done_i`.
- R6: When `cd_en_i` is 1, a collision during the packet body makes the cycle after `cv_done_i` show `retry_o` for one cycle in place of `done_o`.
- R7: After `pkt_done_i`, `tx_en_o` stays 1 until the cycle after `cv_done_i`.
- R8: A low on `coll_n_i` while idle is ignored. The collision flag clears when each new transmission starts.
- R9: A `start_i` sampled during a transmission is ignored. The transmission ends normally, and no new one begins afterwards.
- R10: `done_o` and `retry_o` are never high together, and each is high for only one cycle at a time.
- R11: A collision after the packet checkpoint, during the code-violation phase, does not change the outcome: the transmission ends with `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin a transmission |
| pre_done_i | input | 1 | Strobe: preamble has been sent |
| pkt_done_i | input | 1 | Strobe: packet body has been sent |
| cv_done_i | input | 1 | Strobe: trailing code violation has been sent |
| cd_en_i | input | 1 | Collision detection enable |
| coll_n_i | input | 1 | Active-low collision indication from transceiver |
| tx_en_o | output | 1 | Transmit enable, always driven |
| done_o | output | 1 | One-cycle pulse: packet sent without collision |
| retry_o | output | 1 | One-cycle pulse: collision seen, re-access the channel |

## Verification
The assertions assume that `coll_n_i` and the strobes are synchronous to `clk` and are always at a known level. They do not assume that the strobes come in phase order, because the controller ignores a strobe that does not belong to its current phase. The stimulus changes every input on the falling clock edge and holds it for whole cycles. Each strobe is driven in its own phase as a pulse one cycle long. Collision pulses are placed in each phase in turn, on a checkpoint cycle, and while idle.

// File: rtl/txcoll_pkg.sv
package txcoll_pkg;

    localparam int PHASE_W = 2;

    typedef enum logic [PHASE_W-1:0] {
        PH_IDLE = 2'd0,
        PH_PRE  = 2'd1,
        PH_BODY = 2'd2,
        PH_TAIL = 2'd3
    } phase_e;

    typedef struct packed {
        logic pre;
        logic pkt;
        logic cv;
    } strobe_t;

    function automatic logic phase_active(input phase_e p);
        return p != PH_IDLE;
    endfunction

endpackage

// File: rtl/txcoll_flag.sv
module txcoll_flag (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic arm_i,
    input  logic cd_en_i,
    input  logic coll_n_i,
    output logic seen_o
);
    logic flag_q;
    logic hit;

    assign hit    = arm_i && cd_en_i && !coll_n_i;
    assign seen_o = flag_q || hit;

    always_ff @(posedge clk) begin
        if (rst || clr_i) flag_q <= 1'b0;
        else if (hit)     flag_q <= 1'b1;
    end

    a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr_i) |=> flag_q);
    a_r4_disabled_no_set: assert property (@(posedge clk) disable iff (rst)
        (!flag_q && !cd_en_i) |=> !flag_q);
    a_r8_idle_no_set: assert property (@(posedge clk) disable iff (rst)
        (!flag_q && !arm_i) |=> !flag_q);
endmodule

// File: rtl/txcoll_seq.sv
module txcoll_seq
    import txcoll_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start_i,
    input  strobe_t strb_i,
    input  logic    seen_i,
    output phase_e  phase_o,
    output logic    clr_o,
    output logic    done_o,
    output logic    retry_o
);
    phase_e phase_q, phase_d;
    logic   verdict_q;
    logic   early_abort, late_end;

    assign clr_o       = (phase_q == PH_IDLE) && start_i;
    assign early_abort = (phase_q == PH_PRE) && strb_i.pre && seen_i;
    assign late_end    = (phase_q == PH_TAIL) && strb_i.cv;

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: if (start_i)    phase_d = PH_PRE;
            PH_PRE:  if (strb_i.pre) phase_d = seen_i ? PH_IDLE : PH_BODY;
            PH_BODY: if (strb_i.pkt) phase_d = PH_TAIL;
            PH_TAIL: if (strb_i.cv)  phase_d = PH_IDLE;
            default:                 phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            verdict_q <= 1'b0;
            done_o    <= 1'b0;
            retry_o   <= 1'b0;
        end else begin
            phase_q <= phase_d;
            if (phase_q == PH_BODY && strb_i.pkt) verdict_q <= seen_i;
            done_o  <= late_end && !verdict_q;
            retry_o <= early_abort || (late_end && verdict_q);
        end
    end

    assign phase_o = phase_q;

    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done_o && retry_o));
    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    a_r10_retry_single: assert property (@(posedge clk) disable iff (rst)
        retry_o |=> !retry_o);
    a_r2_start_enters_pre: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && start_i) |=> phase_q == PH_PRE);
    a_r3_early_retry: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_PRE && strb_i.pre && seen_i) |=> (retry_o && phase_q == PH_IDLE));
    a_r7_tail_holds: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_TAIL && !strb_i.cv) |=> phase_q == PH_TAIL);
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_BODY && !strb_i.pkt) |=> phase_q == PH_BODY);
endmodule

// File: rtl/txcoll_top.sv
module txcoll_top
    import txcoll_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic pre_done_i,
    input  logic pkt_done_i,
    input  logic cv_done_i,
    input  logic cd_en_i,
    input  logic coll_n_i,
    output logic tx_en_o,
    output logic done_o,
    output logic retry_o
);
    strobe_t strb;
    phase_e  phase;
    logic    clr, seen;

    assign strb = '{pre: pre_done_i, pkt: pkt_done_i, cv: cv_done_i};

    txcoll_flag u_flag (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (clr),
        .arm_i    (phase_active(phase)),
        .cd_en_i  (cd_en_i),
        .coll_n_i (coll_n_i),
        .seen_o   (seen)
    );

    txcoll_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .strb_i  (strb),
        .seen_i  (seen),
        .phase_o (phase),
        .clr_o   (clr),
        .done_o  (done_o),
        .retry_o (retry_o)
    );

    assign tx_en_o = phase_active(phase);

    a_r5_txen_drops_with_end: assert property (@(posedge clk) disable iff (rst)
        (done_o || retry_o) |-> !tx_en_o);
    a_r2_rise_needs_start: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_en_o) |-> $past(start_i));
endmodule

// File: tb/txcoll_top_tb.sv
module txcoll_top_tb;
    logic clk = 1'b0;
    logic rst, start_i, pre_done_i, pkt_done_i, cv_done_i, cd_en_i, coll_n_i;
    logic tx_en_o, done_o, retry_o;
    int   n_chk = 0;
    int   n_bad = 0;

    always #2.5 clk = ~clk;

    txcoll_top u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .pre_done_i(pre_done_i),
        .pkt_done_i(pkt_done_i), .cv_done_i(cv_done_i), .cd_en_i(cd_en_i),
        .coll_n_i(coll_n_i), .tx_en_o(tx_en_o), .done_o(done_o), .retry_o(retry_o)
    );

    // {cd_en, phase of collision, expected}: phase 0 none, 1 preamble,
    // 2 body, 3 tail, 4 idle before start, 5 same cycle as pre_done.
    // expected 0 done, 1 retry at preamble check, 2 retry at packet end.
    localparam logic [5:0] VEC [0:9] = '{
        {1'b1, 3'd0, 2'd0}, {1'b1, 3'd1, 2'd1}, {1'b1, 3'd2, 2'd2},
        {1'b1, 3'd3, 2'd0}, {1'b1, 3'd4, 2'd0}, {1'b1, 3'd5, 2'd1},
        {1'b0, 3'd1, 2'd0}, {1'b0, 3'd2, 2'd0}, {1'b0, 3'd5, 2'd0},
        {1'b1, 3'd2, 2'd2}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic run_tx(input bit cd, input int ph, input int exp, input bit poke_start);
        cd_en_i = cd;
        if (ph == 4) begin coll_n_i = 1'b0; step(); coll_n_i = 1'b1; end
        start_i = 1'b1; step(); start_i = 1'b0;
        chk(tx_en_o == 1'b1, "R2", "tx_en after start", tx_en_o, 1);
        for (int i = 0; i < 3; i++) begin
            coll_n_i = !(ph == 1 && i == 1);
            step();
        end
        coll_n_i = !(ph == 5);
        pre_done_i = 1'b1; step(); pre_done_i = 1'b0; coll_n_i = 1'b1;
        if (exp == 1) begin
            chk(retry_o == 1'b1, "R3", "retry at preamble check", retry_o, 1);
            chk(tx_en_o == 1'b0, "R3", "tx_en after abort", tx_en_o, 0);
            chk(done_o == 1'b0, "R10", "done with early retry", done_o, 0);
            step();
            chk(retry_o == 1'b0, "R10", "retry width", retry_o, 0);
            return;
        end
        chk(tx_en_o == 1'b1 && retry_o == 1'b0, cd ? "R3" : "R4",
            "continue past preamble", tx_en_o, 1);
        for (int i = 0; i < 3; i++) begin
            coll_n_i = !(ph == 2 && i == 1);
            start_i = poke_start && i == 0;
            step();
        end
        start_i = 1'b0; coll_n_i = 1'b1;
        pkt_done_i = 1'b1; step(); pkt_done_i = 1'b0;
        for (int i = 0; i < 2; i++) begin
            coll_n_i = !(ph == 3 && i == 0);
            step();
            chk(tx_en_o == 1'b1, "R7", "tx_en held in tail", tx_en_o, 1);
        end
        coll_n_i = 1'b1;
        cv_done_i = 1'b1; step(); cv_done_i = 1'b0;
        chk(tx_en_o == 1'b0, "R5", "tx_en after end", tx_en_o, 0);
        if (exp == 2) begin
            chk(retry_o == 1'b1 && done_o == 1'b0, "R6", "retry at packet end", retry_o, 1);
        end else begin
            chk(done_o == 1'b1 && retry_o == 1'b0,
                (ph == 3) ? "R11" : (ph == 4) ? "R8" : cd ? "R5" : "R4",
                "done at packet end", done_o, 1);
        end
        step();
        chk(done_o == 1'b0 && retry_o == 1'b0, "R10", "pulse width", done_o + retry_o, 0);
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; start_i = 0; pre_done_i = 0; pkt_done_i = 0; cv_done_i = 0;
        cd_en_i = 1'b1; coll_n_i = 1'b1;
        repeat (3) step();
        chk(tx_en_o == 0 && done_o == 0 && retry_o == 0, "R1", "outputs in reset",
            tx_en_o + done_o + retry_o, 0);
        rst = 1'b0; step();
        chk(tx_en_o == 0 && done_o == 0 && retry_o == 0, "R1", "outputs after reset",
            tx_en_o + done_o + retry_o, 0);

        foreach (VEC[k]) begin
            run_tx(VEC[k][5], int'(VEC[k][4:2]), int'(VEC[k][1:0]), 1'b0);
            step();
        end

        // R8: a collision at the preamble check leaves the flag set; the next start must clear it
        run_tx(1'b1, 5, 1, 1'b0);
        run_tx(1'b1, 0, 0, 1'b0);

        // R9: start during body is ignored, and no restart follows
        run_tx(1'b1, 0, 0, 1'b1);
        repeat (2) begin
            step();
            chk(tx_en_o == 1'b0, "R9", "no restart after stray start", tx_en_o, 0);
        end

        // R1: reset in the middle of a transmission
        start_i = 1'b1; step(); start_i = 1'b0;
        step();
        rst = 1'b1; step();
        chk(tx_en_o == 0 && done_o == 0 && retry_o == 0, "R1", "outputs on mid-tx reset",
            tx_en_o + done_o + retry_o, 0);
        rst = 1'b0; step();
        chk(tx_en_o == 1'b0, "R1", "idle after mid-tx reset", tx_en_o, 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule